// File: doc/BRIEF.md
# Transfer-Count Data Phase Sequencer

This block sits behind the data register of a parallel-bus disk initiator controller. Each host write to the data register is a byte pushed toward the target, and each host read is a byte pulled from it. A 24-bit transfer count sets how many bytes the current bus phase carries. Every accepted access lowers the count by one. When the count runs out, the block moves to the next bus phase, raises the interrupt flag and reports a completion code.

Bytes written during a phase are gathered in a small buffer. The identify byte from a message-out phase and the command bytes are then visible to the target model. Bytes to be read come from that model on a byte input. The target's choice of the phase after the command, and the length of that phase, also arrive as inputs, because command decoding is not part of this block. Software loads the count and the phase through load strobes before it starts a transfer.

Top module: `xfer_phase_seq`

## Requirements
- R1: After reset the count is 0, the phase is data-out (code 0), INT, DBR and the done pulse are low, the buffer level is 0 and the read byte is 0.
- R2: A count load writes the 24-bit value, which appears as high, middle and low bytes. A phase load writes the phase. Both loads are ignored in a cycle where either data strobe is high, and a phase load with code 4 or 5 is ignored. Phase codes: data-out 0, data-in 1, command 2, status 3, message-out 6, message-in 7.
- R3: With single-byte mode off, a data write while the count is 0 changes nothing: count, phase and level stay the same and no done pulse is produced.
- R4: An accepted data write stores the byte at the current buffer level (byte k at bits 8k+7:8k of the buffer output), raises the level by one up to a maximum of 12, and lowers the count by one.
- R5: In single-byte mode a data write behaves as if the count were 1. Every write completes, and the count is left at 0.
- R6: A write that takes the count to 0 pulses done for one cycle, sets INT and reports status 0x18 OR the new phase. The level returns to 0 whenever the phase changes.
- R7: Completing message-out moves to command (2) and latches the first byte of the phase as the identify byte.
- R8: Completing command moves to the target's next phase, loads the count with the target length, and sets DBR exactly when that length is non-zero. Completing data-out moves to status (3). In other phases the phase is kept.
- R9: A data read in message-in with a count of 0 completes with status 0x85 and leaves the phase unchanged.
- R10: A data read in status with a count of 1 sets the count to 0, moves to message-in (7) and completes with status 0x1F.
- R11: Any other read with a non-zero count returns the target byte, lowers the count and clears INT. If the count reaches 0, the phase moves to status and the read completes with 0x1B.
- R12: If the command-phase input equals 0x60 when a read empties the count, there is no done pulse and the phase is kept, but INT is set and DBR is cleared.
- R13: A host read of the completion status clears INT, unless a completion happens in the same cycle.
- R14: A data read with a count of 0 outside message-in returns 0 and changes neither count, phase nor done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Host write to the data register |
| wr_data | input | 8 | Byte written by the host |
| rd_stb | input | 1 | Host read of the data register |
| rd_byte_in | input | 8 | Next byte from the target model |
| status_rd | input | 1 | Host read of the completion status |
| single_byte | input | 1 | Single-byte mode bit from the command |
| cmd_phase_reg | input | 8 | Command-phase register value |
| cnt_ld | input | 1 | Load the transfer count |
| cnt_ld_val | input | 24 | Count value to load |
| ph_ld | input | 1 | Load the bus phase |
| ph_ld_val | input | 3 | Phase value to load |
| tgt_next_phase | input | 3 | Phase the target enters after the command |
| tgt_len | input | 24 | Byte length of that phase |
| rd_data | output | 8 | Byte returned by the last data read |
| cnt_hi | output | 8 | Count bits 23:16 |
| cnt_mid | output | 8 | Count bits 15:8 |
| cnt_lo | output | 8 | Count bits 7:0 |
| phase | output | 3 | Current bus phase |
| int_flag | output | 1 | Interrupt pending |
| dbr_flag | output | 1 | Data buffer ready |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 8 | Last completion code |
| ident | output | 8 | Latched identify byte |
| buf_level | output | 4 | Bytes held in the write buffer |
| buf_bytes | output | 96 | Write buffer contents, byte 0 lowest |

## Verification
Writes are swept over all six phase codes and over starting counts of 1 to 3. This separates the four phase transitions (message-out, command, data-out, and the phases that stay put) and shows that the level resets only on a real phase change. Reads are swept over counts of 1 to 4 with a distinct byte per position, so an off-by-one in the count or a stale byte shows up. Separate corner runs cover a zero count, single-byte mode, buffer saturation past 12 bytes, the 0x60 hold case, and the two special reads in the status and message-in phases.

// File: rtl/dps_pkg.sv
`timescale 1ns/1ps
package dps_pkg;
  localparam logic [2:0] PH_DOUT = 3'd0;
  localparam logic [2:0] PH_DIN  = 3'd1;
  localparam logic [2:0] PH_CMD  = 3'd2;
  localparam logic [2:0] PH_STAT = 3'd3;
  localparam logic [2:0] PH_MOUT = 3'd6;
  localparam logic [2:0] PH_MIN  = 3'd7;

  localparam logic [7:0] ST_XFER = 8'h18;
  localparam logic [7:0] ST_DISC = 8'h85;

  // phase reached when a write empties the count
  function automatic logic [2:0] wr_done_phase(input logic [2:0] cur, input logic [2:0] tgt);
    case (cur)
      PH_MOUT: return PH_CMD;
      PH_CMD:  return tgt;
      PH_DOUT: return PH_STAT;
      default: return cur;
    endcase
  endfunction

  function automatic logic [7:0] xfer_code(input logic [2:0] ph);
    return ST_XFER | {5'b0, ph};
  endfunction

  function automatic logic phase_legal(input logic [2:0] ph);
    return (ph != 3'd4) && (ph != 3'd5);
  endfunction
endpackage

// File: rtl/dps_count.sv
`timescale 1ns/1ps
module dps_count #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [CW-1:0] upd_val,
  output logic [CW-1:0] cnt,
  output logic          is_zero,
  output logic          is_one
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (upd) cnt <= upd_val;
  end

  assign is_zero = (cnt == '0);
  assign is_one  = (cnt == CW'(1));

  p_count_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cnt == $past(upd_val)));
endmodule

// File: rtl/dps_wbuf.sv
`timescale 1ns/1ps
module dps_wbuf #(
  parameter int DEPTH = 12,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DW-1:0]       din,
  input  logic                clr,
  output logic [LW-1:0]       level,
  output logic [DW-1:0]       head,
  output logic [DEPTH*DW-1:0] flat
);
  logic [DW-1:0] mem [DEPTH];
  logic [LW-1:0] ptr;
  logic          room;

  assign room  = (ptr < LW'(DEPTH));
  assign level = ptr;
  // first byte of the phase, including the one arriving now
  assign head  = (ptr == '0) ? din : mem[0];

  always_ff @(posedge clk) begin
    if (!rst_n)                ptr <= '0;
    else if (clr)              ptr <= '0;
    else if (wr_en && room)    ptr <= ptr + LW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && room) begin
      mem[ptr] <= din;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign flat[g*DW +: DW] = mem[g];
  end

  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  p_level_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && !room) |=> (level == LW'(DEPTH)));
endmodule

// File: rtl/xfer_phase_seq.sv
`timescale 1ns/1ps
module xfer_phase_seq
  import dps_pkg::*;
#(
  parameter int         BUF_DEPTH = 12,
  parameter logic [7:0] HOLD_CODE = 8'h60,
  localparam int        CW        = 24,
  localparam int        LW        = $clog2(BUF_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic [7:0]            wr_data,
  input  logic                  rd_stb,
  input  logic [7:0]            rd_byte_in,
  input  logic                  status_rd,
  input  logic                  single_byte,
  input  logic [7:0]            cmd_phase_reg,
  input  logic                  cnt_ld,
  input  logic [CW-1:0]         cnt_ld_val,
  input  logic                  ph_ld,
  input  logic [2:0]            ph_ld_val,
  input  logic [2:0]            tgt_next_phase,
  input  logic [CW-1:0]         tgt_len,
  output logic [7:0]            rd_data,
  output logic [7:0]            cnt_hi,
  output logic [7:0]            cnt_mid,
  output logic [7:0]            cnt_lo,
  output logic [2:0]            phase,
  output logic                  int_flag,
  output logic                  dbr_flag,
  output logic                  done,
  output logic [7:0]            done_status,
  output logic [7:0]            ident,
  output logic [LW-1:0]         buf_level,
  output logic [BUF_DEPTH*8-1:0] buf_bytes
);
  logic [CW-1:0] cnt, eff_cnt, cnt_nxt, cnt_after;
  logic          cnt_zero, cnt_one, cnt_upd;
  logic [7:0]    buf_head;

  // named events for the assertions
  logic wr_acc, wr_last, cmd_done;
  logic rd_go, rd_disc, rd_stat, rd_acc, rd_last, rd_hold;
  logic ld_ok, ph_ok, done_evt, ph_chg, buf_clr;
  logic [2:0] wr_ph, ph_nxt;
  logic [7:0] code_nxt;

  assign eff_cnt  = single_byte ? CW'(1) : cnt;
  assign wr_acc   = wr_stb && (single_byte || !cnt_zero);
  assign wr_last  = wr_acc && (single_byte || cnt_one);
  assign wr_ph    = wr_done_phase(phase, tgt_next_phase);
  assign cmd_done = wr_last && (phase == PH_CMD);

  assign rd_go    = rd_stb && !wr_stb;
  assign rd_disc  = rd_go && (phase == PH_MIN) && cnt_zero;
  assign rd_stat  = rd_go && (phase == PH_STAT) && cnt_one;
  assign rd_acc   = rd_go && !rd_stat && !cnt_zero;
  assign rd_last  = rd_acc && cnt_one;
  assign rd_hold  = rd_last && (cmd_phase_reg == HOLD_CODE);

  assign ld_ok    = cnt_ld && !wr_stb && !rd_stb;
  assign ph_ok    = ph_ld && !wr_stb && !rd_stb && phase_legal(ph_ld_val);
  assign done_evt = wr_last || rd_disc || rd_stat || (rd_last && !rd_hold);

  always_comb begin
    cnt_upd = 1'b1;
    cnt_nxt = cnt;
    if (wr_acc)       cnt_nxt = cmd_done ? tgt_len : eff_cnt - CW'(1);
    else if (rd_stat) cnt_nxt = '0;
    else if (rd_acc)  cnt_nxt = cnt - CW'(1);
    else if (ld_ok)   cnt_nxt = cnt_ld_val;
    else              cnt_upd = 1'b0;
  end
  assign cnt_after = cnt_upd ? cnt_nxt : cnt;

  always_comb begin
    ph_nxt   = phase;
    code_nxt = done_status;
    if (wr_last) begin
      ph_nxt   = wr_ph;
      code_nxt = xfer_code(wr_ph);
    end else if (rd_disc) begin
      code_nxt = ST_DISC;
    end else if (rd_stat) begin
      ph_nxt   = PH_MIN;
      code_nxt = xfer_code(PH_MIN);
    end else if (rd_last && !rd_hold) begin
      ph_nxt   = PH_STAT;
      code_nxt = xfer_code(PH_STAT);
    end else if (ph_ok) begin
      ph_nxt   = ph_ld_val;
    end
  end

  assign ph_chg  = (ph_nxt != phase);
  assign buf_clr = ph_chg || ph_ok;

  dps_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .upd(cnt_upd), .upd_val(cnt_nxt),
    .cnt(cnt), .is_zero(cnt_zero), .is_one(cnt_one)
  );

  dps_wbuf #(.DEPTH(BUF_DEPTH), .DW(8)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .din(wr_data), .clr(buf_clr),
    .level(buf_level), .head(buf_head), .flat(buf_bytes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_DOUT;
      int_flag    <= 1'b0;
      dbr_flag    <= 1'b0;
      done        <= 1'b0;
      done_status <= '0;
      rd_data     <= '0;
      ident       <= '0;
    end else begin
      phase       <= ph_nxt;
      done        <= done_evt;
      done_status <= code_nxt;
      if (done_evt || rd_hold)           int_flag <= 1'b1;
      else if (status_rd || rd_acc)      int_flag <= 1'b0;
      if (done_evt || rd_hold)           dbr_flag <= (cnt_after != '0);
      if (rd_go)                         rd_data  <= rd_acc ? rd_byte_in : 8'h00;
      if (wr_last && (phase == PH_MOUT)) ident    <= buf_head;
    end
  end

  assign cnt_hi  = cnt[23:16];
  assign cnt_mid = cnt[15:8];
  assign cnt_lo  = cnt[7:0];

  p_phase_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_legal(phase));
  p_zero_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !single_byte && cnt_zero) |=> ($stable(cnt) && $stable(phase) && !done));
  p_done_sets_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int_flag);
  p_disc_in_msgin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == ST_DISC) |-> (phase == PH_MIN && cnt_zero));
  p_status_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (phase == PH_MIN && cnt_zero && done_status == 8'h1F));
  p_hold_no_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hold |=> (!done && int_flag && !dbr_flag));
endmodule

// File: tb/xfer_phase_seq_tb.sv
`timescale 1ns/1ps
module xfer_phase_seq_tb;
  logic        clk = 0, rst_n = 0;
  logic        wr_stb = 0, rd_stb = 0, status_rd = 0, single_byte = 0;
  logic        cnt_ld = 0, ph_ld = 0;
  logic [7:0]  wr_data = 0, rd_byte_in = 0, cmd_phase_reg = 0;
  logic [23:0] cnt_ld_val = 0, tgt_len = 0;
  logic [2:0]  ph_ld_val = 0, tgt_next_phase = 0;
  logic [7:0]  rd_data, cnt_hi, cnt_mid, cnt_lo, done_status, ident;
  logic [2:0]  phase;
  logic        int_flag, dbr_flag, done;
  logic [3:0]  buf_level;
  logic [95:0] buf_bytes;
  int n_chk = 0, n_fail = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  xfer_phase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_byte_in(rd_byte_in), .status_rd(status_rd),
    .single_byte(single_byte), .cmd_phase_reg(cmd_phase_reg),
    .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val), .ph_ld(ph_ld), .ph_ld_val(ph_ld_val),
    .tgt_next_phase(tgt_next_phase), .tgt_len(tgt_len),
    .rd_data(rd_data), .cnt_hi(cnt_hi), .cnt_mid(cnt_mid), .cnt_lo(cnt_lo),
    .phase(phase), .int_flag(int_flag), .dbr_flag(dbr_flag), .done(done),
    .done_status(done_status), .ident(ident), .buf_level(buf_level), .buf_bytes(buf_bytes)
  );

  wire [23:0] cnt_now = {cnt_hi, cnt_mid, cnt_lo};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic load_cnt(input logic [23:0] v);
    cnt_ld = 1; cnt_ld_val = v; tick(); cnt_ld = 0;
  endtask
  task automatic load_ph(input logic [2:0] p);
    ph_ld = 1; ph_ld_val = p; tick(); ph_ld = 0;
  endtask
  task automatic wr(input logic [7:0] b);
    wr_stb = 1; wr_data = b; tick(); wr_stb = 0;
  endtask
  task automatic rd(input logic [7:0] b);
    rd_stb = 1; rd_byte_in = b; tick(); rd_stb = 0;
  endtask
  task automatic ack(); status_rd = 1; tick(); status_rd = 0; endtask

  function automatic logic [2:0] after_wr(input logic [2:0] p, input logic [2:0] tn);
    if (p == 3'd6) return 3'd2;
    if (p == 3'd2) return tn;
    if (p == 3'd0) return 3'd3;
    return p;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] ph_list [6];
    ph_list = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6, 3'd7};
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 count", cnt_now, 0);
    chk("R1 phase", phase, 0);
    chk("R1 flags", {int_flag, dbr_flag, done}, 0);
    chk("R1 level", buf_level, 0);
    chk("R1 rd_data", rd_data, 0);

    // R2 loads and priority
    load_cnt(24'hA5C317);
    chk("R2 hi", cnt_hi, 8'hA5);
    chk("R2 mid", cnt_mid, 8'hC3);
    chk("R2 lo", cnt_lo, 8'h17);
    load_cnt(0);
    cnt_ld = 1; cnt_ld_val = 24'h000009; wr(8'h11); cnt_ld = 0;
    chk("R2 load blocked by strobe", cnt_now, 0);
    load_ph(3'd5);
    chk("R2 illegal phase ignored", phase, 0);

    // R3 zero-count write ignored
    wr(8'h22);
    chk("R3 count", cnt_now, 0);
    chk("R3 phase", phase, 0);
    chk("R3 level", buf_level, 0);
    chk("R3 done", done, 0);

    // R4/R6/R7/R8 write sweep over phases and counts
    for (int i = 0; i < 6; i++) begin
      for (int n = 1; n <= 3; n++) begin
        logic [2:0] p, ep;
        logic [23:0] tl, ec;
        p  = ph_list[i];
        tl = (n == 3) ? 24'd0 : 24'(n * 5);
        tgt_next_phase = (n == 2) ? 3'd0 : 3'd1;
        tgt_len = tl;
        load_ph(p); load_cnt(24'(n)); ack();
        for (int k = 1; k <= n; k++) begin
          wr(8'h40 + 8'(k));
          if (k < n) begin
            chk("R4 count dec", cnt_now, 24'(n - k));
            chk("R4 level", buf_level, 4'(k));
            chk("R4 no done", done, 0);
          end
        end
        ep = after_wr(p, tgt_next_phase);
        ec = (p == 3'd2) ? tl : 24'd0;
        chk("R6 done", done, 1);
        chk("R6 int", int_flag, 1);
        chk("R6 status", done_status, 8'h18 | {5'b0, ep});
        chk("R8 phase", phase, ep);
        chk("R8 count", cnt_now, ec);
        chk("R8 dbr", dbr_flag, (ec != 0));
        chk("R6 level", buf_level, (ep != p) ? 4'd0 : 4'(n));
        if (p == 3'd6) chk("R7 ident", ident, 8'h41);
        if (p == 3'd2) chk("R4 byte0", buf_bytes[7:0], 8'h41);
        tick();
        chk("R6 done one cycle", done, 0);
      end
    end

    // R4 saturation at 12
    load_ph(3'd1); load_cnt(24'd15);
    for (int k = 0; k < 14; k++) wr(8'h80 + 8'(k));
    chk("R4 saturated level", buf_level, 12);
    chk("R4 count after 14", cnt_now, 1);
    for (int k = 0; k < 12; k++) chk("R4 byte", buf_bytes[k*8 +: 8], 8'h80 + 8'(k));
    wr(8'hFF);
    chk("R6 kept phase", phase, 1);
    chk("R6 kept level", buf_level, 12);
    chk("R6 status data-in", done_status, 8'h19);

    // R5 single-byte mode
    single_byte = 1;
    load_ph(3'd0); load_cnt(0);
    wr(8'h33);
    chk("R5 done", done, 1);
    chk("R5 status", done_status, 8'h1B);
    chk("R5 phase", phase, 3);
    load_ph(3'd6); load_cnt(24'd5);
    wr(8'h5A);
    chk("R5 phase", phase, 2);
    chk("R5 count", cnt_now, 0);
    chk("R7 ident single", ident, 8'h5A);
    single_byte = 0;

    // R13 status read clears INT
    chk("R13 int before", int_flag, 1);
    ack();
    chk("R13 int cleared", int_flag, 0);

    // R9 disconnect read
    load_ph(3'd7); load_cnt(0);
    rd(8'h77);
    chk("R9 done", done, 1);
    chk("R9 status", done_status, 8'h85);
    chk("R9 phase", phase, 7);
    chk("R9 rd_data", rd_data, 0);

    // R10 status read
    load_ph(3'd3); load_cnt(1);
    rd(8'h66);
    chk("R10 count", cnt_now, 0);
    chk("R10 phase", phase, 7);
    chk("R10 status", done_status, 8'h1F);
    chk("R10 done", done, 1);

    // R11 read sweep
    cmd_phase_reg = 8'h00;
    for (int n = 1; n <= 4; n++) begin
      load_ph(3'd1); load_cnt(24'(n));
      for (int k = 1; k <= n; k++) begin
        rd(8'(n * 16 + k));
        chk("R11 byte", rd_data, 8'(n * 16 + k));
        chk("R11 count", cnt_now, 24'(n - k));
        if (k < n) chk("R11 int cleared", int_flag, 0);
      end
      chk("R11 phase", phase, 3);
      chk("R11 status", done_status, 8'h1B);
      chk("R11 done", done, 1);
      chk("R11 dbr", dbr_flag, 0);
    end

    // R12 hold case, DBR first raised by a command completion
    load_ph(3'd2); load_cnt(1);
    tgt_next_phase = 3'd1; tgt_len = 24'd2;
    wr(8'h12);
    chk("R8 dbr set", dbr_flag, 1);
    chk("R8 phase data-in", phase, 1);
    ack();
    cmd_phase_reg = 8'h60;
    rd(8'hA1);
    rd(8'hA2);
    chk("R12 no done", done, 0);
    chk("R12 int", int_flag, 1);
    chk("R12 dbr", dbr_flag, 0);
    chk("R12 phase", phase, 1);
    chk("R12 byte", rd_data, 8'hA2);
    cmd_phase_reg = 8'h00;

    // R14 zero-count read outside message-in
    rd(8'hEE);
    chk("R14 rd_data", rd_data, 0);
    chk("R14 count", cnt_now, 0);
    chk("R14 phase", phase, 1);
    chk("R14 done", done, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule